// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator byte, a second byte and a four-bit operation code, and it forms a result byte combinationally. A five-bit condition set is kept in flip-flops. The five flags are sign, zero, half carry, parity and carry. They are rewritten at a rising clock edge only when the update strobe is high, and each operation writes only the flags it owns.

The carry used by add-with-carry, subtract-with-borrow, the rotates through carry and complement-carry is the block's own registered carry flag. A 16-bit status word joins the accumulator input with a packed flag byte. Surrounding logic uses it to push the machine state to a stack.

Top module: `alu8_flags_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `flags_o` is cleared at that edge. Flag bit order is `flags_o[4]`=sign, `[3]`=zero, `[2]`=half carry, `[1]`=parity, `[0]`=carry.
- R2: When `upd_i` is low at a rising edge, `flags_o` keeps its value.
- R3: Add (code 0) gives A+B mod 256, and add-with-carry (code 1) gives A+B+CY mod 256. Carry is the carry out of bit 7 and half carry is the carry out of bit 3.
- R4: Subtract (code 2) gives A−B mod 256, and subtract-with-borrow (code 3) gives A−B−CY mod 256. Carry is 1 exactly when a borrow occurs. Half carry is the carry out of bit 3 of A + ~B + (1−borrow-in).
- R5: Zero is 1 when the result byte is 0, sign equals result bit 7, and parity is 1 when the result has an even count of ones. These three are written by codes 0–6, 8, 9 and 14.
- R6: AND (code 4), OR (code 5) and XOR (code 6) combine A and B bit by bit, and they clear both carry and half carry.
- R7: Increment (code 8) gives A+1 and decrement (code 9) gives A−1. Carry is left unchanged. Half carry is 1 when A[3:0]=15 on increment and when A[3:0]≠0 on decrement.
- R8: Complement (code 7) gives ~A and changes no flag.
- R9: Circular left rotate (code 10) gives {A[6:0],A[7]} with carry set to A[7]. Circular right rotate (code 11) gives {A[0],A[7:1]} with carry set to A[0]. Only carry is written.
- R10: Left rotate through carry (code 12) gives {A[6:0],CY} with carry set to A[7]. Right rotate through carry (code 13) gives {CY,A[7:1]} with carry set to A[0]. Only carry is written.
- R11: Clear (code 14) gives 0 and sets zero=1, parity=1, sign=0, carry=0 and half carry=0.
- R12: Complement-carry (code 15) inverts only the carry flag and passes A to the result.
- R13: `status_o[15:8]` equals `acc_i`. `status_o[7:0]` has sign in bit 7, zero in bit 6, half carry in bit 4, parity in bit 2 and carry in bit 0, with bits 5, 3 and 1 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand (register, memory byte or immediate) |
| upd_i | input | 1 | Flag update strobe |
| result_o | output | 8 | Combinational result byte |
| flags_o | output | 5 | Registered flags {sign, zero, half carry, parity, carry} |
| status_o | output | 16 | Accumulator joined with the packed flag byte |

## Verification
The assertions assume that `op_i`, `acc_i` and `opnd_i` stay fixed from the falling edge before a rising edge until after that edge. Relations such as zero following the sampled result therefore compare the values that were actually applied. The assertions also assume that the strobe is never high during reset. The bench changes every input only at falling edges and keeps `upd_i` low while `rst` is high, so both assumptions hold. The stimulus covers all sixteen codes with the strobe both high and low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W = 8;
    localparam int OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMA = 4'd7,
        OP_INR = 4'd8,
        OP_DCR = 4'd9,
        OP_RLC = 4'd10,
        OP_RRC = 4'd11,
        OP_RAL = 4'd12,
        OP_RAR = 4'd13,
        OP_CLR = 4'd14,
        OP_CMC = 4'd15
    } alu_op_e;

    // condition set, most significant field first
    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    // which flag groups an operation is allowed to rewrite
    typedef struct packed {
        logic szp;
        logic ac;
        logic cy;
    } flag_wr_t;

    function automatic logic even_par(input logic [ALU_W-1:0] v);
        return ~^v;
    endfunction

    function automatic flag_wr_t op_flag_mask(input alu_op_e op);
        flag_wr_t m;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB,
            OP_AND, OP_OR, OP_XOR, OP_CLR:   m = '{szp: 1'b1, ac: 1'b1, cy: 1'b1};
            OP_INR, OP_DCR:                  m = '{szp: 1'b1, ac: 1'b1, cy: 1'b0};
            OP_RLC, OP_RRC, OP_RAL, OP_RAR,
            OP_CMC:                          m = '{szp: 1'b0, ac: 1'b0, cy: 1'b1};
            default:                         m = '{szp: 1'b0, ac: 1'b0, cy: 1'b0};
        endcase
        return m;
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INR, OP_DCR};
    endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hcout_o
);
    localparam int LO = DW / 2;
    localparam int HI = DW - LO;

    logic [LO:0] lo_sum;
    logic [HI:0] hi_sum;

    always_comb begin
        lo_sum  = {1'b0, x_i[LO-1:0]} + {1'b0, y_i[LO-1:0]} + {{LO{1'b0}}, cin_i};
        hi_sum  = {1'b0, x_i[DW-1:LO]} + {1'b0, y_i[DW-1:LO]} + {{HI{1'b0}}, lo_sum[LO]};
        sum_o   = {hi_sum[HI-1:0], lo_sum[LO-1:0]};
        cout_o  = hi_sum[HI];
        hcout_o = lo_sum[LO];
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = ALU_W
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CMA: res_o = ~a_i;
            OP_RLC: begin res_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
            OP_RRC: begin res_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
            OP_RAL: begin res_o = {a_i[DW-2:0], cy_i};      cy_o = a_i[DW-1]; end
            OP_RAR: begin res_o = {cy_i, a_i[DW-1:1]};      cy_o = a_i[0];    end
            OP_CLR: res_o = '0;
            OP_CMC: begin res_o = a_i; cy_o = ~cy_i; end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_i,
    input  flag_wr_t   wr_i,
    input  alu_flags_t nxt_i,
    output alu_flags_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (upd_i) begin
            if (wr_i.szp) begin
                q_o.s <= nxt_i.s;
                q_o.z <= nxt_i.z;
                q_o.p <= nxt_i.p;
            end
            if (wr_i.ac) q_o.ac <= nxt_i.ac;
            if (wr_i.cy) q_o.cy <= nxt_i.cy;
        end
    end
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
    import alu8_pkg::*;
#(
    parameter int DW = ALU_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DW-1:0]     acc_i,
    input  logic [DW-1:0]     opnd_i,
    input  logic              upd_i,
    output logic [DW-1:0]     result_o,
    output logic [4:0]        flags_o,
    output logic [2*DW-1:0]   status_o
);
    alu_op_e     op;
    alu_flags_t  flg_q;
    alu_flags_t  flg_d;
    flag_wr_t    wr;

    logic [DW-1:0] add_y;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_cout;
    logic          add_hc;
    logic [DW-1:0] bit_res;
    logic          bit_cy;
    logic          sub_mode;
    logic [DW-1:0] fbyte;

    assign op = alu_op_e'(op_i);

    // operand shaping for the shared adder
    always_comb begin
        add_y    = opnd_i;
        add_cin  = 1'b0;
        sub_mode = 1'b0;
        unique case (op)
            OP_ADC: add_cin = flg_q.cy;
            OP_SUB: begin add_y = ~opnd_i; add_cin = 1'b1;      sub_mode = 1'b1; end
            OP_SBB: begin add_y = ~opnd_i; add_cin = ~flg_q.cy; sub_mode = 1'b1; end
            OP_INR: begin add_y = '0;      add_cin = 1'b1; end
            OP_DCR: begin add_y = '1;      add_cin = 1'b0; end
            default: ;
        endcase
    end

    alu8_adder #(.DW(DW)) u_add (
        .x_i    (acc_i),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .hcout_o(add_hc)
    );

    alu8_bitops #(.DW(DW)) u_bits (
        .op_i (op),
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .cy_i (flg_q.cy),
        .res_o(bit_res),
        .cy_o (bit_cy)
    );

    assign result_o = is_arith(op) ? add_sum : bit_res;
    assign wr       = op_flag_mask(op);

    always_comb begin
        flg_d.s  = result_o[DW-1];
        flg_d.z  = (result_o == '0);
        flg_d.p  = even_par(result_o);
        flg_d.ac = is_arith(op) ? add_hc : 1'b0;
        if (is_arith(op))
            flg_d.cy = sub_mode ? ~add_cout : add_cout;
        else
            flg_d.cy = bit_cy;
    end

    alu8_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .upd_i(upd_i),
        .wr_i (wr),
        .nxt_i(flg_d),
        .q_o  (flg_q)
    );

    always_comb begin
        fbyte    = '0;
        fbyte[7] = flg_q.s;
        fbyte[6] = flg_q.z;
        fbyte[4] = flg_q.ac;
        fbyte[2] = flg_q.p;
        fbyte[0] = flg_q.cy;
    end

    assign flags_o  = flg_q;
    assign status_o = {acc_i, fbyte};
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic [7:0]  acc_i,
    input logic        upd_i,
    input logic [7:0]  result_o,
    input logic [4:0]  flags_o,
    input logic [15:0] status_o
);
    logic szp_op;
    assign szp_op = (op_i <= 4'd6) || (op_i == 4'd8) || (op_i == 4'd9) || (op_i == 4'd14);

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> flags_o == 5'd0);

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flags_o));

    a_r5_zero_tracks_result: assert property (@(posedge clk) disable iff (rst)
        (upd_i && szp_op) |=> flags_o[3] == ($past(result_o) == 8'd0));

    a_r5_parity_tracks_result: assert property (@(posedge clk) disable iff (rst)
        (upd_i && szp_op) |=> flags_o[1] == ~^$past(result_o));

    a_r6_logic_clears_carries: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));

    a_r7_step_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (op_i == OP_INR || op_i == OP_DCR)) |=> flags_o[0] == $past(flags_o[0]));

    a_r8_complement_no_flags: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == OP_CMA) |=> $stable(flags_o));

    a_r9_rlc_carry_from_msb: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == OP_RLC) |=> flags_o[0] == $past(acc_i[7]));

    a_r11_clear_gives_zero: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CLR) |-> result_o == 8'd0);

    a_r12_cmc_inverts_carry: assert property (@(posedge clk) disable iff (rst)
        (upd_i && op_i == OP_CMC) |=> flags_o[0] != $past(flags_o[0]));

    a_r13_status_word: assert property (@(posedge clk) disable iff (rst)
        (status_o[15:8] == acc_i) && (status_o[0] == flags_o[0]) && (status_o[6] == flags_o[3]));
endmodule

bind alu8_flags_unit alu8_flags_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .upd_i   (upd_i),
    .result_o(result_o),
    .flags_o (flags_o),
    .status_o(status_o)
);

// File: tb/alu8_flags_unit_tb.sv
module alu8_flags_unit_tb;
    logic        clk;
    logic        rst;
    logic [3:0]  op_i;
    logic [7:0]  acc_i;
    logic [7:0]  opnd_i;
    logic        upd_i;
    logic [7:0]  result_o;
    logic [4:0]  flags_o;
    logic [15:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] res;
        logic [4:0] flg;
        logic [7:0] acc;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic [4:0]  mflags;
    logic [15:0] lfsr;

    alu8_flags_unit u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .upd_i(upd_i), .result_o(result_o), .flags_o(flags_o), .status_o(status_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:   return "R3";
            4'd2, 4'd3:   return "R4";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7:         return "R8";
            4'd8, 4'd9:   return "R7";
            4'd10, 4'd11: return "R9";
            4'd12, 4'd13: return "R10";
            4'd14:        return "R11";
            default:      return "R12";
        endcase
    endfunction

    // flag order: {S, Z, AC, P, CY}
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [4:0] f, output logic [7:0] r, output logic [4:0] nf);
        int s;
        logic cy, szp;
        cy  = f[0];
        nf  = f;
        szp = 1'b0;
        r   = a;
        case (op)
            4'd0, 4'd1: begin
                s = int'(a) + int'(b) + ((op == 4'd1) ? int'(cy) : 0);
                r = s[7:0]; nf[0] = (s > 255);
                nf[2] = (int'(a & 8'h0f) + int'(b & 8'h0f) + ((op == 4'd1) ? int'(cy) : 0)) > 15;
                szp = 1'b1;
            end
            4'd2, 4'd3: begin
                int bin;
                bin = (op == 4'd3) ? int'(cy) : 0;
                s = int'(a) - int'(b) - bin;
                r = s[7:0]; nf[0] = (s < 0);
                nf[2] = (int'(a & 8'h0f) + int'((~b) & 8'h0f) + (1 - bin)) > 15;
                szp = 1'b1;
            end
            4'd4: begin r = a & b; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
            4'd5: begin r = a | b; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
            4'd6: begin r = a ^ b; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
            4'd7: r = ~a;
            4'd8: begin r = a + 8'd1; nf[2] = (a[3:0] == 4'hf); szp = 1'b1; end
            4'd9: begin r = a - 8'd1; nf[2] = (a[3:0] != 4'h0); szp = 1'b1; end
            4'd10: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
            4'd11: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
            4'd12: begin r = {a[6:0], cy};   nf[0] = a[7]; end
            4'd13: begin r = {cy, a[7:1]};   nf[0] = a[0]; end
            4'd14: begin r = 8'h00; nf[0] = 0; nf[2] = 0; szp = 1'b1; end
            default: begin r = a; nf[0] = ~cy; end
        endcase
        if (szp) begin
            nf[4] = r[7];
            nf[3] = (r == 8'h00);
            nf[1] = ~^r;
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic upd, input string tag);
        logic [7:0] r;
        logic [4:0] nf;
        exp_t it;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; upd_i = upd;
        model(op, a, b, mflags, r, nf);
        if (upd) mflags = nf;
        it.res = r; it.flg = mflags; it.acc = a; it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic logic [7:0] pack_flags(input logic [4:0] f);
        return {f[4], f[3], 1'b0, f[2], 1'b0, f[1], 1'b0, f[0]};
    endfunction

    // monitor: result before the edge, flags and status word after it
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (result_o !== it.res) begin
                    fails++;
                    $display("FAIL %s result op=%0d: actual %h expected %h", it.tag, op_i, result_o, it.res);
                end
                @(posedge clk);
                #1;
                checks++;
                if (flags_o !== it.flg) begin
                    fails++;
                    $display("FAIL %s flags: actual %b expected %b", (upd_i ? it.tag : "R2"), flags_o, it.flg);
                end
                checks++;
                if (status_o !== {it.acc, pack_flags(it.flg)}) begin
                    fails++;
                    $display("FAIL R13 status: actual %h expected %h", status_o, {it.acc, pack_flags(it.flg)});
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 4'd0; acc_i = 8'h00; opnd_i = 8'h00; upd_i = 1'b0;
        mflags = 5'b00000;
        lfsr   = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: load flags with upd, then reset again and check clear
        rst = 1'b0;
        apply(4'd15, 8'hff, 8'h00, 1'b1, "R12");
        apply(4'd2, 8'h00, 8'h01, 1'b1, "R4");
        repeat (2) @(negedge clk);
        upd_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        mflags = 5'b00000;
        #1;
        checks++;
        if (flags_o !== 5'b00000 || status_o[7:0] !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset flags: actual %b expected 00000", flags_o);
        end
        rst = 1'b0;

        // R3 add corners: overflow to zero, half carry, add with carry
        apply(4'd0, 8'h80, 8'h80, 1'b1, "R3");
        apply(4'd0, 8'h0f, 8'h01, 1'b1, "R3");
        apply(4'd15, 8'h00, 8'h00, 1'b1, "R12");
        apply(4'd1, 8'hfe, 8'h01, 1'b1, "R3");
        // R4 subtract with borrow and without
        apply(4'd2, 8'h10, 8'h20, 1'b1, "R4");
        apply(4'd3, 8'h05, 8'h05, 1'b1, "R4");
        apply(4'd2, 8'h42, 8'h42, 1'b1, "R5");
        // R6 logic clears carry
        apply(4'd0, 8'hff, 8'h01, 1'b1, "R3");
        apply(4'd4, 8'hf0, 8'h3c, 1'b1, "R6");
        apply(4'd5, 8'h81, 8'h02, 1'b1, "R6");
        apply(4'd6, 8'haa, 8'haa, 1'b1, "R6");
        // R8 complement keeps flags
        apply(4'd15, 8'h00, 8'h00, 1'b1, "R12");
        apply(4'd7, 8'h5a, 8'h00, 1'b1, "R8");
        // R7 increment/decrement wrap with carry held
        apply(4'd8, 8'hff, 8'h00, 1'b1, "R7");
        apply(4'd9, 8'h00, 8'h00, 1'b1, "R7");
        apply(4'd9, 8'h10, 8'h00, 1'b1, "R7");
        // R9 / R10 rotates
        apply(4'd10, 8'h81, 8'h00, 1'b1, "R9");
        apply(4'd11, 8'h01, 8'h00, 1'b1, "R9");
        apply(4'd12, 8'h40, 8'h00, 1'b1, "R10");
        apply(4'd13, 8'h02, 8'h00, 1'b1, "R10");
        apply(4'd13, 8'h03, 8'h00, 1'b1, "R10");
        // R11 clear, R12 complement carry twice
        apply(4'd14, 8'h77, 8'h33, 1'b1, "R11");
        apply(4'd15, 8'h12, 8'h00, 1'b1, "R12");
        apply(4'd15, 8'h34, 8'h00, 1'b1, "R12");
        // R2 no strobe: flags must hold
        apply(4'd0, 8'h80, 8'h80, 1'b0, "R2");
        apply(4'd14, 8'h00, 8'h00, 1'b0, "R2");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic [7:0] a, b;
            logic       u;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = lfsr[3:0]; a = lfsr[11:4];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr[7:0]; u = lfsr[9] | lfsr[10];
            apply(op, a, b, u, tag_of(op));
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule